// File: doc/BRIEF.md
# Burst-Scoped CRC-16 Transfer Checker

This block keeps a running 16-bit cyclic redundancy check over the data words that cross a parallel disk interface during one DMA burst. A burst is the interval during which the DMA acknowledge input is high. The block restarts its register from a fixed seed when the acknowledge rises. It then folds in each word that the strobe-valid qualifier marks, one word per clock.

When the controller side asks to close the burst, the block freezes the result and raises a drive enable. The pad logic then places the value on the shared 16-bit data lines, and the device latches it when the acknowledge falls. The device compares that value with its own and reports any difference. Strobe timing, pad tri-stating and the device-side comparison sit outside this block.

Top module: `udma_crc16_checker`

## Requirements
- R1: While reset (`rst_n` low, active low) is applied and after its release, `crc_out` reads 0x4ABA and `crc_drive` reads 0.
- R2: In the first clock cycle in which `dma_ack` is sampled high after being low, the register restarts from the seed 0x4ABA. If `strobe_valid` is also high in that cycle, the word is folded into the seed rather than into the old value.
- R3: Each qualified word updates the register in one clock, and the result shows on `crc_out` after that edge. The generator polynomial is x^16+x^12+x^5+1 (0x1021), with no reflection and no final inversion. Data bit 15 is shifted in first: for each bit, feedback = crc[15] xor data bit, crc shifts left by one, and it is XORed with 0x1021 when the feedback is 1.
- R4: A word presented while `strobe_valid` is low leaves `crc_out` unchanged.
- R5: While `dma_ack` is low, `crc_out` holds its value and `burst_end` and `strobe_valid` have no effect.
- R6: `burst_end` sampled high while `dma_ack` is high raises `crc_drive` on the next cycle. A word qualified in that same cycle is still included. From then until `dma_ack` falls, `crc_drive` stays high, `crc_out` stays frozen, and qualified words are ignored.
- R7: `crc_drive` falls in the cycle after `dma_ack` is sampled low. `crc_out` keeps the final value until the next burst starts.
- R8: A new burst carries no state from an earlier one. Its result depends only on its own qualified words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_ack | input | 1 | DMA acknowledge; high for the whole burst |
| strobe_valid | input | 1 | Marks a word moved by a valid strobe edge |
| data_in | input | 16 | Data word on the interface |
| burst_end | input | 1 | Request to close the burst and present the CRC |
| crc_out | output | 16 | Current or final CRC value |
| crc_drive | output | 1 | Enable for the pads to drive `crc_out` onto the data lines |

## Verification
A wrong register value shows on `crc_out` in the cycle after the word that caused it. The bench compares every step of each burst with a model, so a fault in the fold equation, the qualification or the seed reload is caught within one clock. A failure to freeze shows as a changed `crc_out` while `crc_drive` is high, again within one cycle of the ignored word. A wrong drive-enable release shows one cycle after the acknowledge falls. A scoreboard pairs each burst's expected final value with the cycle in which `crc_drive` rises.

// File: rtl/udma_crc16_checker.sv
module udma_crc16_checker #(
  parameter int W = 16,
  parameter logic [W-1:0] SEED = 16'h4ABA,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dma_ack,
  input  logic         strobe_valid,
  input  logic [W-1:0] data_in,
  input  logic         burst_end,
  output logic [W-1:0] crc_out,
  output logic         crc_drive
);

  function automatic logic [W-1:0] fold(input logic [W-1:0] c_in, input logic [W-1:0] d);
    logic [W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = W - 1; i >= 0; i--) begin
      fb = c[W-1] ^ d[i];
      c = {c[W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  logic         ack_q, hold;
  logic [W-1:0] crc;
  logic         start, take;
  logic [W-1:0] base;

  assign start = dma_ack & ~ack_q;
  assign take  = dma_ack & strobe_valid & ~hold;
  assign base  = start ? SEED : crc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc   <= SEED;
      ack_q <= 1'b0;
      hold  <= 1'b0;
    end else begin
      ack_q <= dma_ack;
      if (take)       crc <= fold(base, data_in);
      else if (start) crc <= SEED;
      if (!dma_ack)       hold <= 1'b0;
      else if (burst_end) hold <= 1'b1;
    end
  end

  assign crc_out   = crc;
  assign crc_drive = hold;

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (crc_out == SEED && !crc_drive)); // R1
  AST_SEED_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && !ack_q && !strobe_valid) |=> crc_out == SEED); // R2
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_valid && ack_q && dma_ack) |=> $stable(crc_out)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_ack |=> ($stable(crc_out) && !crc_drive)); // R5
  AST_DRIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_drive && dma_ack) |=> (crc_drive && $stable(crc_out))); // R6
  AST_DRIVE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && burst_end) |=> crc_drive); // R6
  AST_DRIVE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_ack |=> !crc_drive); // R7

endmodule

// File: tb/udma_crc16_checker_test.sv
module udma_crc16_checker_test;
  logic clk = 0, rst_n = 0, dma_ack = 0, strobe_valid = 0, burst_end = 0;
  logic [15:0] data_in = 0;
  logic [15:0] crc_out;
  logic crc_drive;
  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  logic [15:0] model;
  logic drive_seen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  udma_crc16_checker uut (.clk(clk), .rst_n(rst_n), .dma_ack(dma_ack), .strobe_valid(strobe_valid),
    .data_in(data_in), .burst_end(burst_end), .crc_out(crc_out), .crc_drive(crc_drive));

  function automatic logic [15:0] ref_crc(input logic [15:0] c_in, input logic [15:0] d);
    logic [15:0] c = c_in;
    for (int i = 15; i >= 0; i--) begin
      if (c[15] ^ d[i]) c = {c[14:0], 1'b0} ^ 16'h1021;
      else c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // monitor: pop expected final CRC when the drive enable rises
  always @(negedge clk) begin
    if (crc_drive && !drive_seen) begin
      if (exp_q.size() == 0) chk(0, "R6 unexpected drive", crc_out, 16'h0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(crc_out == e, "R6 final crc at drive", crc_out, e);
      end
    end
    drive_seen <= crc_drive;
  end

  // driver: one burst; gap_every inserts unqualified words; first_in_seed puts a word in the ack-rise cycle
  task automatic burst(input int n, input logic [15:0] start_val, input int gap_every, input bit first_in_seed);
    logic [15:0] d;
    model = 16'h4ABA;
    dma_ack = 1;
    if (!first_in_seed) begin
      strobe_valid = 0; data_in = 16'hDEAD;
      step();
      chk(crc_out == 16'h4ABA, "R2 seed after ack rise", crc_out, 16'h4ABA);
    end
    for (int i = 0; i < n; i++) begin
      if (gap_every != 0 && i % gap_every == 1) begin
        strobe_valid = 0; data_in = ~start_val ^ 16'(i);
        step();
        chk(crc_out == model, "R4 unqualified word ignored", crc_out, model);
      end
      d = start_val * 16'(i + 3) ^ 16'(i << 5);
      strobe_valid = 1; data_in = d;
      model = ref_crc(model, d);
      step();
      chk(crc_out == model, i == 0 && first_in_seed ? "R2 word in seed cycle" : "R3 fold per word",
          crc_out, model);
    end
    strobe_valid = 0; burst_end = 1;
    exp_q.push_back(model);
    step();
    burst_end = 0;
    chk(crc_drive == 1, "R6 drive raised", {15'b0, crc_drive}, 16'h1);
    strobe_valid = 1; data_in = 16'h1234;
    step(); step();
    strobe_valid = 0;
    chk(crc_out == model && crc_drive, "R6 frozen while driving", crc_out, model);
    dma_ack = 0;
    step();
    chk(crc_drive == 0, "R7 drive released", {15'b0, crc_drive}, 16'h0);
    chk(crc_out == model, "R7 value kept after ack low", crc_out, model);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk(crc_out == 16'h4ABA && !crc_drive, "R1 reset state", crc_out, 16'h4ABA);
    rst_n = 1;
    step();
    chk(crc_out == 16'h4ABA && !crc_drive, "R1 after release", crc_out, 16'h4ABA);
    // idle: qualified words and burst_end without ack
    strobe_valid = 1; burst_end = 1; data_in = 16'hFFFF;
    step(); step();
    strobe_valid = 0; burst_end = 0;
    chk(crc_out == 16'h4ABA && !crc_drive, "R5 idle inputs ignored", crc_out, 16'h4ABA);
    // single known word: 0x0000 from seed
    model = ref_crc(16'h4ABA, 16'h0000);
    burst(1, 16'h0000, 0, 0);
    burst(6, 16'h1357, 0, 0);
    burst(8, 16'hA5C3, 3, 1);
    step();
    burst(4, 16'hFFFF, 2, 1);
    // R8: repeat the same burst after others, same result
    burst(6, 16'h1357, 0, 0);
    chk(crc_out == ref_crc(ref_crc(ref_crc(ref_crc(ref_crc(ref_crc(16'h4ABA,
        16'h1357*16'd3), 16'h1357*16'd4 ^ 16'd32), 16'h1357*16'd5 ^ 16'd64),
        16'h1357*16'd6 ^ 16'd96), 16'h1357*16'd7 ^ 16'd128), 16'h1357*16'd8 ^ 16'd160),
        "R8 no carry-over", crc_out, model);
    step();
    chk(exp_q.size() == 0, "R6 all bursts presented", 16'(exp_q.size()), 16'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule